// File: doc/BRIEF.md
# Streaming Five-Point Stencil Adder

This block takes a square grid of N by N unsigned samples, delivered in row-major raster order as a stream, and for every grid position produces the sum of that sample and its four direct neighbours: above, below, left and right. Neighbours are found at fixed offsets in the one-dimensional stream, one step and one row-length away in each direction. Two row-length delay lines in on-chip memory keep the samples from the last two rows, so every neighbour is present when it is needed. Any neighbour that falls outside the grid adds nothing to the sum.

The grid edge N is chosen at run time. The host sets it on a configuration input and then pulses start. Samples are then accepted whenever the input valid strobe is high. Output starts once the row below the first output row has begun to arrive, and it follows the raster order of the input. After the final sample has been accepted, the block runs on by itself until the whole grid has been output, and it then returns to idle. An edge length that is not a power of two, or that lies outside the supported range, is rejected and raises an error flag.

Top module: `stencil5_stream`

## Requirements
- R1: For a grid position at row y and column x, the output value is the sum of the input values at (y-1,x), (y,x-1), (y,x), (y,x+1) and (y+1,x). The output appears in the same row-major order as the input.
- R2: A neighbour outside the grid contributes 0. This applies to row 0 (no neighbour above), row N-1 (none below), column 0 (none to the left) and column N-1 (none to the right).
- R3: The first output of a frame is registered on the clock edge that accepts input number N+2, counting the first accepted input as number 1. Each later output follows the acceptance of one more input.
- R4: After the N*N-th input has been accepted, the block produces all of the remaining outputs with no further input, so that exactly N*N outputs are produced. It then returns to idle.
- R5: N is taken from `n_cfg` when `start` is sampled high while the block is idle. Successive frames may use different valid sizes.
- R6: A start with an `n_cfg` value that is not a power of two, or that lies outside NMIN..NMAX (defaults 256..2048), sets `cfg_err` to 1 on the next clock edge and does not start a frame. While `cfg_err` is 1, no output is produced.
- R7: A `start` pulse that arrives while a frame is running is ignored. The frame goes on with its original N.
- R8: `in_valid` has no effect while the block is idle, and none once all N*N inputs of the frame have been accepted.
- R9: Output values are DW+3 bits wide, so an all-maximum neighbourhood gives 5*(2^DW-1) with no overflow.
- R10: A start with a valid N clears `cfg_err` on the next clock edge.
- R11: After reset, `out_valid` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle frame start request |
| n_cfg | input | clog2(NMAX)+2 | Grid edge length supplied by the host |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Unsigned input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | DW+3 | Five-point neighbourhood sum |
| cfg_err | output | 1 | Last start request carried an unsupported N |

## Verification
The assertions check on every cycle that sums stay within the five-sample bound, that the error flag excludes both frame activity and output, that a frame only ever ends on the cycle of its last output, that output occurs only while a frame is running, and that the accepted-input count never passes N*N. Correct neighbour selection, the zero contribution at each of the four edges, the exact N+1 latency, the self-driven drain and the effect of varying N can only be shown by the bench's scenarios. In those scenarios, every output is compared against sums computed from the grid the bench sent.

// File: rtl/stencil5_stream.sv
module stencil5_stream #(
  parameter int DW   = 16,
  parameter int NMIN = 256,
  parameter int NMAX = 2048
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [$clog2(NMAX)+1:0]      n_cfg,
  input  logic                         in_valid,
  input  logic [DW-1:0]                in_data,
  output logic                         out_valid,
  output logic [DW+2:0]                out_data,
  output logic                         cfg_err
);
  localparam int AW = $clog2(NMAX);
  localparam int NW = AW + 2;
  localparam int CW = 2 * AW + 2;
  localparam int OW = DW + 3;

  logic [DW-1:0] row_a [NMAX];
  logic [DW-1:0] row_b [NMAX];

  logic          run;
  logic [NW-1:0] n_r, pre, orow, ocol;
  logic [AW-1:0] ptr;
  logic [CW-1:0] in_cnt;
  logic [DW-1:0] dn_r, c1, c2, u1;

  wire [NW-1:0] nm1    = n_r - NW'(1);
  wire [CW-1:0] nsq    = CW'(n_r) * CW'(n_r);
  wire          fill   = in_cnt == nsq;
  wire          step   = run && (fill || in_valid);
  wire [DW-1:0] x      = fill ? '0 : in_data;
  wire [DW-1:0] rd_a   = row_a[ptr];
  wire [DW-1:0] rd_b   = row_b[ptr];
  wire          primed = pre == n_r + NW'(1);
  wire          last   = orow == nm1 && ocol == nm1;

  wire n_ok = n_cfg >= NW'(NMIN) && n_cfg <= NW'(NMAX) &&
              (n_cfg & (n_cfg - NW'(1))) == '0;

  wire [OW-1:0] t_up = (orow != '0) ? OW'(u1)   : '0;
  wire [OW-1:0] t_dn = (orow != nm1) ? OW'(dn_r) : '0;
  wire [OW-1:0] t_lf = (ocol != '0) ? OW'(c2)   : '0;
  wire [OW-1:0] t_rt = (ocol != nm1) ? OW'(rd_a) : '0;
  wire [OW-1:0] sum  = t_up + t_dn + t_lf + t_rt + OW'(c1);

  always_ff @(posedge clk) begin
    if (step) begin
      row_a[ptr] <= x;
      row_b[ptr] <= rd_a;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= 1'b0;
      cfg_err   <= 1'b0;
      n_r       <= NW'(NMIN);
      pre       <= '0;
      orow      <= '0;
      ocol      <= '0;
      ptr       <= '0;
      in_cnt    <= '0;
      dn_r      <= '0;
      c1        <= '0;
      c2        <= '0;
      u1        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!run && start) begin
        if (n_ok) begin
          run     <= 1'b1;
          cfg_err <= 1'b0;
          n_r     <= n_cfg;
          pre     <= '0;
          orow    <= '0;
          ocol    <= '0;
          ptr     <= '0;
          in_cnt  <= '0;
        end else begin
          cfg_err <= 1'b1;
        end
      end
      if (step) begin
        ptr    <= ({2'b00, ptr} == nm1) ? '0 : ptr + AW'(1);
        in_cnt <= fill ? in_cnt : in_cnt + CW'(1);
        dn_r   <= x;
        c1     <= rd_a;
        c2     <= c1;
        u1     <= rd_b;
        if (!primed) begin
          pre <= pre + NW'(1);
        end else begin
          out_valid <= 1'b1;
          out_data  <= sum;
          if (ocol == nm1) begin
            ocol <= '0;
            orow <= orow + NW'(1);
          end else begin
            ocol <= ocol + NW'(1);
          end
          if (last) run <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/stencil5_stream_chk.sv
module stencil5_stream_chk #(
  parameter int DW = 16,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          cfg_err,
  input logic          out_valid,
  input logic [DW+2:0] out_data,
  input logic [CW-1:0] in_cnt,
  input logic [CW-1:0] nsq
);
  localparam logic [DW+2:0] MAXSUM = (DW+3)'(5) * (DW+3)'({DW{1'b1}});

  // R9
  out_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data <= MAXSUM);

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!out_valid && !run));

  // R4
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> out_valid);

  // R3
  out_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(run));

  // R8
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> in_cnt <= nsq);
endmodule

bind stencil5_stream stencil5_stream_chk #(
  .DW(DW),
  .CW(2 * $clog2(NMAX) + 2)
) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .run(run),
  .cfg_err(cfg_err),
  .out_valid(out_valid),
  .out_data(out_data),
  .in_cnt(in_cnt),
  .nsq(nsq)
);

// File: tb/stencil5_stream_test.sv
module stencil5_stream_test;
  localparam int DW = 16, NMIN = 4, NMAX = 16;
  localparam int NW = $clog2(NMAX) + 2;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0;
  logic [NW-1:0] n_cfg = '0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, cfg_err;
  logic [DW+2:0] out_data;

  stencil5_stream #(.DW(DW), .NMIN(NMIN), .NMAX(NMAX)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_cfg(n_cfg),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .cfg_err(cfg_err));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int exp_q[$];
  int grid[NMAX*NMAX];
  int sent = 0, first_n = 0;
  bit first_pending = 0, gapless = 0, done = 0;
  string tag = "R1";

  task automatic chk(bit ok, string t, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8/R6 unexpected output", int'(out_data), -1);
      end else begin
        chk(int'(out_data) == exp_q[0], tag, int'(out_data), exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (first_pending) begin
        first_pending = 0;
        if (gapless) chk(sent == first_n + 2, "R3 latency", sent, first_n + 2);
      end
    end
  end

  function automatic int nsum(int n, int c);
    int y = c / n, xx = c % n, s = grid[c];
    if (y > 0) s += grid[c-n];
    if (y < n-1) s += grid[c+n];
    if (xx > 0) s += grid[c-1];
    if (xx < n-1) s += grid[c+1];
    return s;
  endfunction

  task automatic pulse_start(int n);
    start = 1; n_cfg = NW'(n);
    @(posedge clk); #1;
    start = 0;
  endtask

  // pat: 0 ramp, 1 ones, 2 max, 3 random
  task automatic frame(int n, int pat, bit gappy, bit mid_start, string t, bit clr_chk);
    for (int i = 0; i < n*n; i++)
      case (pat)
        0: grid[i] = i * 7 + 3;
        1: grid[i] = 1;
        2: grid[i] = 65535;
        default: grid[i] = int'($urandom % 65536);
      endcase
    for (int c = 0; c < n*n; c++) exp_q.push_back(nsum(n, c));
    tag = t; first_n = n; gapless = !gappy; first_pending = 1; sent = 0;
    pulse_start(n);
    if (clr_chk) chk(cfg_err == 0, "R10 error cleared", int'(cfg_err), 0);
    for (int i = 0; i < n*n; i++) begin
      if (gappy && ($urandom % 3 == 0)) begin
        in_valid = 0; in_data = 16'hDEAD;
        @(posedge clk); #1;
      end
      in_valid = 1; in_data = DW'(grid[i]);
      if (mid_start && i == n*n/2) begin start = 1; n_cfg = NW'(NMIN); end
      @(posedge clk); #1;
      start = 0;
      sent++;
    end
    in_valid = 1; in_data = 16'hBEEF;
    for (int w = 0; w < 2000 && exp_q.size() != 0; w++) begin
      @(posedge clk); #1;
    end
    in_valid = 0;
    chk(exp_q.size() == 0, "R4 drain completes", exp_q.size(), 0);
    exp_q.delete();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic bad_start(int n);
    pulse_start(n);
    chk(cfg_err == 1, "R6 error flag", int'(cfg_err), 1);
    in_valid = 1;
    for (int i = 0; i < 40; i++) begin
      in_data = DW'(i); @(posedge clk); #1;
    end
    in_valid = 0;
    chk(cfg_err == 1, "R6 error holds", int'(cfg_err), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R11 reset out_valid", int'(out_valid), 0);
    chk(cfg_err == 0, "R11 reset cfg_err", int'(cfg_err), 0);
    @(posedge clk); #1;
    // R8: inputs while idle do nothing
    in_valid = 1;
    for (int i = 0; i < 10; i++) begin in_data = DW'(i); @(posedge clk); #1; end
    in_valid = 0;
    frame(4, 0, 0, 0, "R1 ramp n4", 0);
    frame(4, 1, 0, 0, "R2 edges n4", 0);
    frame(8, 0, 0, 0, "R5 ramp n8", 0);
    frame(16, 3, 0, 0, "R5 random n16", 0);
    frame(8, 3, 1, 0, "R1 gaps n8", 0);
    frame(8, 2, 0, 0, "R9 max n8", 0);
    frame(8, 0, 0, 1, "R7 mid start", 0);
    bad_start(5);
    frame(4, 3, 0, 0, "R10 after error", 1);
    bad_start(32);
    bad_start(2);
    bad_start(0);
    frame(16, 1, 1, 0, "R2 edges n16", 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule